// File: doc/BRIEF.md
# Interrupt Status and Enable Unit

This block gathers single-cycle event pulses from a network controller's transmit, receive, timer and bus-error logic. Each pulse sets a sticky bit in a status register. A matching enable register selects which sources take part in two summary bits, one for normal events and one for abnormal events. A single interrupt line goes to the host whenever an enabled summary bit is set.

Software reads the status register and the enable register through a plain address, write-enable and read-data port. It acknowledges events by writing ones to the status address. A host that polls instead of taking interrupts still sees every event, because a status bit latches whether or not its source is enabled.

Top module: `irq_status_unit`

## Requirements
- R1: Status bit positions, with bits 3, 9, 10, 12 and 14 reading zero:

  | Event input | Status bit |
  |---|---|
  | evt_i[0] transmit done | 0 |
  | evt_i[1] transmit stopped | 1 |
  | evt_i[2] transmit idle | 2 |
  | evt_i[3] receive error | 4 |
  | evt_i[4] transmit underflow | 5 |
  | evt_i[5] receive done | 6 |
  | evt_i[6] no receive buffer | 7 |
  | evt_i[7] receive died | 8 |
  | evt_i[8] timer | 11 |
  | evt_i[9] bus error | 13 |

  The abnormal summary is bit 15 and the normal summary is bit 16. The status register is at address 0 and the enable register is at address 1. Any other address reads zero.
- R2: A pulse on an event input sets its status bit at the next clock edge. The bit stays set until it is acknowledged.
- R3: Writing to address 0 clears each status bit whose write-data bit is one. Bits written with zero are unchanged.
- R4: Write data above bit 16 has no effect on any status bit, on either summary bit or on the enable register.
- R5: When an event pulse and an acknowledge of the same bit fall in the same cycle, the bit stays set.
- R6: A status bit latches and reads back whether or not its enable bit is set.
- R7: The enable register shares the status bit layout. A write to address 1 stores the defined bits and stores zero in the undefined bits. The value 0x1A0F5 reads back unchanged.
- R8: The normal summary bit is set at an edge if the next status value has transmit done, transmit idle or receive done set with its enable bit set. The enable bit used is the one held before that edge. The summary bit is sticky until acknowledged.
- R9: The abnormal summary bit follows the same rule over transmit stopped, underflow, receive error, no buffer, receive died, timer and bus error.
- R10: An acknowledge of a summary bit clears it only if no enabled member is still set after that same write.
- R11: irq_o is high exactly when (status bit 16 AND enable bit 16) OR (status bit 15 AND enable bit 15).
- R12: Reset clears the status register, the enable register and irq_o.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| evt_i | input | 10 | Event pulses, mapped as in R1 |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for reg_addr_i |
| irq_o | output | 1 | Interrupt to host |

## Verification
The bench goes after the same-cycle race between an event and its acknowledge. A design that lets the clear win there loses an event outright.

It also acknowledges a summary bit while an enabled member is still pending. A summary built as a plain sticky flag would drop the interrupt with work still outstanding. A summary built without stickiness would fall the moment its member is disabled.

Writes carrying junk above bit 16, and the enable value 0x1A0F5, expose a decoder that uses the full data width or masks the wrong bits. Randomly interleaved events, enables and acknowledges show any slip in the group membership of the two summaries.

// File: rtl/irq_status_pkg.sv
package irq_status_pkg;
  localparam int NUM_SRC = 10;
  localparam int STAT_W  = 17;
  localparam int BIT_ABN = 15;
  localparam int BIT_NRM = 16;

  // status bit for each event input
  function automatic int src_bit(input int i);
    case (i)
      0: src_bit = 0;
      1: src_bit = 1;
      2: src_bit = 2;
      3: src_bit = 4;
      4: src_bit = 5;
      5: src_bit = 6;
      6: src_bit = 7;
      7: src_bit = 8;
      8: src_bit = 11;
      default: src_bit = 13;
    endcase
  endfunction

  localparam logic [STAT_W-1:0] NRM_GRP  = 17'h00045;
  localparam logic [STAT_W-1:0] ABN_GRP  = 17'h029B2;
  localparam logic [STAT_W-1:0] SRC_MASK = NRM_GRP | ABN_GRP;
  localparam logic [STAT_W-1:0] DEF_MASK = SRC_MASK | 17'h18000;
endpackage

// File: rtl/irq_evt_latch.sv
module irq_evt_latch #(
  parameter int N = 10
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [N-1:0] evt_i,
  input  logic [N-1:0] ack_i,
  output logic [N-1:0] flag_o,
  output logic [N-1:0] flag_nxt_o
);
  for (genvar g = 0; g < N; g++) begin : g_src
    // set has priority over acknowledge
    assign flag_nxt_o[g] = evt_i[g] | (flag_o[g] & ~ack_i[g]);

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) flag_o[g] <= 1'b0;
      else         flag_o[g] <= flag_nxt_o[g];
    end

    // R2
    evt_sets_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      evt_i[g] |=> flag_o[g]);
    // R3
    hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (flag_o[g] && !ack_i[g]) |=> flag_o[g]);
    // R3
    clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ack_i[g] && !evt_i[g]) |=> !flag_o[g]);
  end
endmodule

// File: rtl/irq_enable_reg.sv
module irq_enable_reg
  import irq_status_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [STAT_W-1:0] wdata_i,
  output logic [STAT_W-1:0] en_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   en_o <= '0;
    else if (wr_i) en_o <= wdata_i & DEF_MASK;
  end

  // R7
  en_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(en_o));
  // R7
  en_rsvd_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (en_o & ~DEF_MASK) == '0);
endmodule

// File: rtl/irq_summary.sv
module irq_summary
  import irq_status_pkg::*;
#(
  parameter logic [STAT_W-1:0] GRP = NRM_GRP
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [STAT_W-1:0] stat_nxt_i,
  input  logic [STAT_W-1:0] en_i,
  input  logic              ack_i,
  output logic              sum_o
);
  logic hit;
  assign hit = |(stat_nxt_i & en_i & GRP);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) sum_o <= 1'b0;
    else         sum_o <= hit | (sum_o & ~ack_i);
  end

  // R8 R9
  sum_set_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    hit |=> sum_o);
  // R10
  sum_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ack_i && !hit) |=> !sum_o);
endmodule

// File: rtl/irq_status_unit.sv
module irq_status_unit
  import irq_status_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int ADDR_W = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NUM_SRC-1:0] evt_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              irq_o
);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(1);

  logic              wr_stat, wr_en;
  logic [STAT_W-1:0] ack_vec, wdat, en_q, stat_nxt, stat_vec;
  logic [NUM_SRC-1:0] ack_src, flag, flag_nxt;
  logic              sum_nrm, sum_abn;
  logic              unused_hi;

  assign wdat      = reg_wdata_i[STAT_W-1:0];
  assign unused_hi = ^reg_wdata_i[DATA_W-1:STAT_W];
  assign wr_stat   = reg_we_i && (reg_addr_i == A_STAT);
  assign wr_en     = reg_we_i && (reg_addr_i == A_EN);
  assign ack_vec   = wr_stat ? wdat : '0;

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_map
    assign ack_src[g] = ack_vec[src_bit(g)];
  end

  irq_evt_latch #(.N(NUM_SRC)) u_latch (
    .clk_i, .rst_ni, .evt_i, .ack_i(ack_src),
    .flag_o(flag), .flag_nxt_o(flag_nxt)
  );

  always_comb begin
    stat_nxt = '0;
    stat_vec = '0;
    for (int i = 0; i < NUM_SRC; i++) begin
      stat_nxt[src_bit(i)] = flag_nxt[i];
      stat_vec[src_bit(i)] = flag[i];
    end
    stat_vec[BIT_ABN] = sum_abn;
    stat_vec[BIT_NRM] = sum_nrm;
  end

  irq_enable_reg u_en (
    .clk_i, .rst_ni, .wr_i(wr_en), .wdata_i(wdat), .en_o(en_q)
  );

  irq_summary #(.GRP(NRM_GRP)) u_sum_nrm (
    .clk_i, .rst_ni, .stat_nxt_i(stat_nxt), .en_i(en_q),
    .ack_i(ack_vec[BIT_NRM]), .sum_o(sum_nrm)
  );

  irq_summary #(.GRP(ABN_GRP)) u_sum_abn (
    .clk_i, .rst_ni, .stat_nxt_i(stat_nxt), .en_i(en_q),
    .ack_i(ack_vec[BIT_ABN]), .sum_o(sum_abn)
  );

  assign irq_o = (sum_nrm & en_q[BIT_NRM]) | (sum_abn & en_q[BIT_ABN]);

  always_comb begin
    reg_rdata_o = '0;
    if (reg_addr_i == A_STAT)    reg_rdata_o[STAT_W-1:0] = stat_vec;
    else if (reg_addr_i == A_EN) reg_rdata_o[STAT_W-1:0] = en_q;
  end

  // R11
  irq_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (sum_nrm || sum_abn));
  // R12
  rst_clear_chk: assert property (@(posedge clk_i)
    $rose(rst_ni) |-> (stat_vec == '0 && en_q == '0));
  // R1
  rsvd_zero_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stat_vec & ~DEF_MASK) == '0);
endmodule

// File: tb/irq_status_unit_bench.sv
module irq_status_unit_bench;
  localparam logic [16:0] NRM = 17'h00045;
  localparam logic [16:0] ABN = 17'h029B2;
  localparam logic [16:0] DEF = 17'h1A9F7;

  logic        clk = 0, rst_n = 0;
  logic [9:0]  evt = '0;
  logic        we = 0;
  logic [1:0]  addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic        irq;
  int checks = 0, fails = 0;
  logic [16:0] m_stat, m_en;
  logic        m_sn, m_sa;

  always #10 clk = ~clk;

  irq_status_unit u_irq_status_unit (
    .clk_i(clk), .rst_ni(rst_n), .evt_i(evt), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata), .irq_o(irq)
  );

  function automatic logic [16:0] map_evt(input logic [9:0] e);
    int pos[10] = '{0, 1, 2, 4, 5, 6, 7, 8, 11, 13};
    logic [16:0] r = '0;
    for (int i = 0; i < 10; i++) r[pos[i]] = e[i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic step(input logic [9:0] e, input logic w,
                      input logic [1:0] a, input logic [31:0] d);
    logic [16:0] ack, nxt;
    evt = e; we = w; addr = a; wdata = d;
    ack = (w && a == 2'd0) ? d[16:0] : '0;
    nxt = map_evt(e) | (m_stat & ~ack);
    m_sn = (|(nxt & m_en & NRM)) | (m_sn & ~ack[16]);
    m_sa = (|(nxt & m_en & ABN)) | (m_sa & ~ack[15]);
    m_stat = nxt;
    if (w && a == 2'd1) m_en = d[16:0] & DEF;
    @(posedge clk); @(negedge clk);
    evt = '0; we = 0;
  endtask

  task automatic verify(input string req);
    addr = 2'd0; #1;
    chk(req, rdata, {15'b0, m_sn, m_sa, m_stat[14:0]});
    addr = 2'd1; #1;
    chk(req, rdata, {15'b0, m_en});
    chk({req, " irq R11"}, {31'b0, irq},
        {31'b0, (m_sn & m_en[16]) | (m_sa & m_en[15])});
  endtask

  initial begin
    #3000000;
    fails++;
    $display("FAIL watchdog");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'h1A0F5));
    m_stat = '0; m_en = '0; m_sn = 0; m_sa = 0;
    repeat (3) @(negedge clk);
    // R12 reset state
    verify("R12");
    rst_n = 1;
    @(negedge clk);

    // R1 R6: each source latches with nothing enabled
    for (int i = 0; i < 10; i++) begin
      step(10'(1 << i), 0, 0, 0);
      verify("R1 R6");
    end
    // R2 sticky
    step('0, 0, 0, 0); verify("R2");
    // R4 junk above bit 16 with zero low part
    step('0, 1, 0, 32'hFFFE_0000); verify("R4");
    // R3 partial clear
    step('0, 1, 0, 32'h0000_0055); verify("R3");
    // R5 event and ack same cycle
    step(10'h001, 1, 0, 32'h0000_0001); verify("R5");
    // R7 enable value and junk
    step('0, 1, 1, 32'hFFFF_FFFF); verify("R7 R4");
    step('0, 1, 1, 32'h0001_A0F5); verify("R7");
    // R8 R9 summaries from pending bits
    step(10'h021, 0, 0, 0); verify("R8");
    step(10'h200, 0, 0, 0); verify("R9");
    // R10 ack summary while member pending
    step('0, 1, 0, 32'h0001_8000); verify("R10");
    // clear members and summaries together
    step('0, 1, 0, 32'h0001_FFFF); verify("R10 R3");
    // R9 disabled member (timer, bit 11) raises no summary
    step(10'h100, 0, 0, 0); verify("R9 R6");
    step('0, 1, 0, 32'h0001_FFFF); verify("R3");
    // R4 ack junk leaves enable intact
    step(10'h008, 1, 2, 32'hFFFF_FFFF); verify("R4 R1");

    // random mix
    for (int n = 0; n < 3000; n++) begin
      logic [9:0] e;
      logic w;
      logic [1:0] a;
      logic [31:0] d;
      e = 10'($urandom) & 10'($urandom) & 10'($urandom);
      w = ($urandom % 4) == 0;
      a = 2'($urandom);
      d = $urandom;
      if (($urandom % 8) == 0) begin
        d = 32'h0001_A0F5;
        a = 2'd1;
      end
      step(e, w, a, d);
      verify("R2 R3 R8 R9 R10 R11");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule